// File: doc/BRIEF.md
# Rising-Edge Dead-Band Delay with Buffered Delay Update

The block sits between a PWM comparator and an output driver. It holds back the rising edge of a single PWM waveform by a programmable number of clock cycles, while every falling edge goes through at once. This opens a dead interval before a switch turns on. If the programmed delay is as long as the high pulse or longer, that pulse is removed from the output entirely.

The 12-bit delay is written through a single-cycle write strobe. An update-mode input chooses when a written value replaces the active delay:
- at once;
- at the next counter-zero strobe from the PWM counter;
- at the first counter-zero strobe after a global sync request has been recorded.

Until it takes effect, a written value waits in a shadow register. A later write overwrites it. When the enable is low, the output is a copy of the input.

Top module: `dbrise_gen`

## Requirements
- R1: After reset the active delay is 0 and the output is low while the input is low. With delay 0, the output equals the input in the same cycle.
- R2: With `en` low, `pwm_out` equals `pwm_in` in every cycle, whatever delay is programmed.
- R3: With `en` high and active delay D, for a high input pulse of W cycles that begins in cycle 0, `pwm_out` is high in cycles D through W-1 and low before cycle D.
- R4: If D is greater than or equal to W, `pwm_out` stays low for the whole pulse.
- R5: In any cycle where `pwm_in` is low, `pwm_out` is low. A low cycle aborts the count in progress, and the next rising edge starts a fresh count of D cycles.
- R6: With `upd_mode` 2'b00 or 2'b01 (immediate), a value written in cycle t is the active delay from cycle t+1. Such a write also discards any pending value.
- R7: With `upd_mode` 2'b10 (local sync), a written value becomes pending. It becomes active in the cycle after the next `cnt_zero` strobe. Until then the old delay stays in use.
- R8: With `upd_mode` 2'b11 (global sync), a pending value becomes active only after a `cnt_zero` strobe that occurs while a global sync request is recorded. A `cnt_zero` strobe with no recorded request leaves the active delay unchanged.
- R9: A write that arrives while an earlier value is pending replaces that value. The earlier value is never used.
- R10: A `gsync_req` strobe is recorded and held until the next `cnt_zero` strobe in global mode, which consumes it. A later `cnt_zero` strobe with no new request loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Dead-band enable. When low, the output copies the input |
| pwm_in | input | 1 | PWM waveform to be delayed |
| cnt_zero | input | 1 | One-cycle strobe sent when the PWM counter reaches zero |
| gsync_req | input | 1 | One-cycle global sync request strobe |
| upd_mode | input | 2 | Update timing: 00/01 immediate, 10 local sync, 11 global sync |
| wr_en | input | 1 | Delay write strobe |
| wr_data | input | 12 | Delay value in clock cycles |
| pwm_out | output | 1 | Input waveform with its rising edge delayed |

## Verification
The output is combinational from the current input and the registered state. A falling edge, or the zero-delay case, therefore shows on `pwm_out` in the same cycle as the input change. A delayed rising edge shows exactly D cycles after the input rose. A write, a zero strobe or a sync request that is sampled at one clock edge affects the output from the following cycle onward.

The bench changes inputs 2 ns after a rising edge and samples 4 ns later, inside the same cycle. It counts pulse cycles from the rising input edge, then compares the first high index and the number of high cycles with the values derived from R3 and R4.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    localparam int DLY_W = 12;

    typedef enum logic [1:0] {
        UPD_NOW     = 2'b00,
        UPD_NOW_ALT = 2'b01,
        UPD_LOCAL   = 2'b10,
        UPD_GLOBAL  = 2'b11
    } upd_mode_e;

    typedef struct packed {
        logic             valid;
        logic [DLY_W-1:0] value;
    } shadow_t;

    function automatic logic mode_buffered(input upd_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/dbr_shadow.sv
module dbr_shadow
    import dbr_pkg::*;
#(
    parameter int W = DLY_W
) (
    input  logic         clk,
    input  logic         rst,
    input  upd_mode_e    mode,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         cnt_zero,
    input  logic         gsync_req,
    output logic [W-1:0] active
);

    logic [W-1:0] active_q;
    logic [W-1:0] pend_val_q;
    logic         pend_vld_q;
    logic         gsync_q;
    logic         consume;
    logic         zero_load;
    logic         wr_now;
    logic         wr_buf;

    assign wr_now    = wr_en && !mode_buffered(mode);
    assign wr_buf    = wr_en && mode_buffered(mode);
    assign consume   = cnt_zero && gsync_q && (mode == UPD_GLOBAL);
    assign zero_load = pend_vld_q && ((cnt_zero && mode == UPD_LOCAL) || consume);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= '0;
            pend_val_q <= '0;
            pend_vld_q <= 1'b0;
            gsync_q    <= 1'b0;
        end else begin
            gsync_q <= (gsync_q && !consume) || gsync_req;
            if (wr_now)
                active_q <= wr_data;
            else if (zero_load)
                active_q <= pend_val_q;
            if (wr_buf) begin
                pend_val_q <= wr_data;
                pend_vld_q <= 1'b1;
            end else if (wr_now || zero_load) begin
                pend_vld_q <= 1'b0;
            end
        end
    end

    assign active = active_q;

    assert_imm_load_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mode[1]) |=> (active == $past(wr_data)));

    assert_local_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == UPD_LOCAL && !cnt_zero && !wr_en) |=> $stable(active));

    assert_global_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == UPD_GLOBAL && !gsync_q && !wr_en) |=> $stable(active));

endmodule

// File: rtl/dbr_edge_det.sv
module dbr_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sig;
    end

    assign rise = sig && !prev_q;

endmodule

// File: rtl/dbr_rise_delay.sv
module dbr_rise_delay
    import dbr_pkg::*;
#(
    parameter int W = DLY_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         pwm_in,
    input  logic         rise,
    input  logic [W-1:0] delay,
    output logic         pwm_out
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] elapsed_q;
    logic [W-1:0] elapsed_now;

    assign elapsed_now = rise ? '0 : elapsed_q;

    always_ff @(posedge clk) begin
        if (rst || !pwm_in)
            elapsed_q <= '0;
        else if (rise)
            elapsed_q <= {{(W-1){1'b0}}, 1'b1};
        else if (elapsed_q != CNT_MAX)
            elapsed_q <= elapsed_q + 1'b1;
    end

    always_comb begin
        if (en) pwm_out = pwm_in && (elapsed_now >= delay);
        else    pwm_out = pwm_in;
    end

    assert_fall_low_R5: assert property (@(posedge clk) disable iff (rst)
        !pwm_in |-> !pwm_out);

    assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
        !en |-> (pwm_out == pwm_in));

endmodule

// File: rtl/dbrise_gen.sv
module dbrise_gen
    import dbr_pkg::*;
#(
    parameter int W = DLY_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         pwm_in,
    input  logic         cnt_zero,
    input  logic         gsync_req,
    input  logic [1:0]   upd_mode,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         pwm_out
);

    upd_mode_e    mode;
    logic [W-1:0] active_dly;
    logic         rise;

    assign mode = upd_mode_e'(upd_mode);

    dbr_shadow #(.W(W)) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cnt_zero  (cnt_zero),
        .gsync_req (gsync_req),
        .active    (active_dly)
    );

    dbr_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (pwm_in),
        .rise (rise)
    );

    dbr_rise_delay #(.W(W)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .pwm_in  (pwm_in),
        .rise    (rise),
        .delay   (active_dly),
        .pwm_out (pwm_out)
    );

    assert_zero_follow_R1: assert property (@(posedge clk) disable iff (rst)
        (en && active_dly == '0) |-> (pwm_out == pwm_in));

endmodule

// File: tb/dbrise_gen_bench.sv
module dbrise_gen_bench;

    typedef struct packed {
        logic [11:0] d;
        logic [7:0]  w;
        logic [7:0]  first;
        logic [7:0]  high;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{12'd0,  8'd5,  8'd0,   8'd5},
        '{12'd3,  8'd10, 8'd3,   8'd7},
        '{12'd1,  8'd2,  8'd1,   8'd1},
        '{12'd4,  8'd4,  8'd255, 8'd0},
        '{12'd6,  8'd3,  8'd255, 8'd0},
        '{12'd10, 8'd11, 8'd10,  8'd1}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        en = 1;
    logic        pwm_in = 0;
    logic        cnt_zero = 0;
    logic        gsync_req = 0;
    logic [1:0]  upd_mode = 2'b00;
    logic        wr_en = 0;
    logic [11:0] wr_data = '0;
    logic        pwm_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dbrise_gen u_dbrise_gen (
        .clk(clk), .rst(rst), .en(en), .pwm_in(pwm_in), .cnt_zero(cnt_zero),
        .gsync_req(gsync_req), .upd_mode(upd_mode), .wr_en(wr_en),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic sample();
        #4;
    endtask

    task automatic wr(input logic [1:0] m, input logic [11:0] v);
        tick();
        upd_mode = m; wr_en = 1; wr_data = v;
        tick();
        wr_en = 0;
    endtask

    task automatic zero_strobe();
        tick(); cnt_zero = 1;
        tick(); cnt_zero = 0;
    endtask

    task automatic sync_strobe();
        tick(); gsync_req = 1;
        tick(); gsync_req = 0;
    endtask

    task automatic pulse(input int w, input int gap, output int first, output int highs);
        first = 255; highs = 0;
        for (int k = 0; k < w; k++) begin
            tick(); pwm_in = 1; sample();
            if (pwm_out) begin
                highs++;
                if (first == 255) first = k;
            end
        end
        tick(); pwm_in = 0; sample();
        chk(pwm_out == 0, "R5 fall low", pwm_out, 0);
        for (int g = 0; g < gap; g++) tick();
    endtask

    task automatic run_pulse(input int w, input int ef, input int eh, input string tag);
        int f, h;
        pulse(w, 2, f, h);
        chk(f == ef, {tag, " first"}, f, ef);
        chk(h == eh, {tag, " highs"}, h, eh);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int f, h;
        repeat (3) tick();
        sample();
        chk(pwm_out == 0, "R1 reset out", pwm_out, 0);
        tick(); rst = 0;
        run_pulse(3, 0, 3, "R1 zero delay");

        for (int i = 0; i < NV; i++) begin
            wr(2'b00, VECS[i].d);
            run_pulse(int'(VECS[i].w), int'(VECS[i].first), int'(VECS[i].high),
                      (VECS[i].high == 0) ? "R4 vec" : "R3 R6 vec");
        end

        wr(2'b01, 12'd2);
        run_pulse(5, 2, 3, "R6 alt mode");

        wr(2'b00, 12'd5);
        en = 0;
        run_pulse(4, 0, 4, "R2 disabled");
        en = 1;

        wr(2'b10, 12'd2);
        run_pulse(8, 5, 3, "R7 held before zero");
        zero_strobe();
        run_pulse(8, 2, 6, "R7 after zero");

        wr(2'b10, 12'd7);
        wr(2'b10, 12'd1);
        zero_strobe();
        run_pulse(8, 1, 7, "R9 rewrite");

        wr(2'b11, 12'd3);
        zero_strobe();
        run_pulse(8, 1, 7, "R8 zero without sync");
        sync_strobe();
        run_pulse(8, 1, 7, "R10 sync held");
        zero_strobe();
        run_pulse(8, 3, 5, "R8 global load");
        wr(2'b11, 12'd6);
        zero_strobe();
        run_pulse(8, 3, 5, "R10 sync consumed");

        wr(2'b00, 12'd4);
        pulse(2, 0, f, h);
        chk(h == 0, "R5 short pulse highs", h, 0);
        run_pulse(6, 4, 2, "R5 restart");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule